// File: doc/BRIEF.md
# Register Window Controller

This block tracks where a windowed integer register file currently stands. It holds the current window pointer and four counts: windows that can be saved, windows that can be restored, clean windows, and windows that belong to another address space. Each cycle it takes at most one request: save, restore, return-style restore or flush-windows. It then either applies the request or reports a trap that a handler must service first. The register storage and the trap handler are outside the block.

A trap is reported as a registered code, together with a vector field. The field is taken from one of two window-state inputs, chosen by whether the other-window count is nonzero. A write port loads all five state values at once, so that trap handlers and context switches can set up the window state. The number of windows is a parameter, and pointer wrap-around does not assume a power of two.

Top module: `rwin_ctrl`

## Requirements
- R1: Synchronous active-high reset sets the pointer to 0, can-save to NWIN-2, can-restore to 0, clean to NWIN-2, other to 0, and the trap code to none (0).
- R2: While `wr_en` is high, all five state values load from the write inputs on the clock edge. The request on `req_op` in that cycle is ignored and the trap code becomes none.
- R3: Request codes are 0 idle, 1 save, 2 restore, 3 return, 4 flush. A save with can-save nonzero and clean not equal to can-restore moves the pointer up by 1 modulo NWIN, decrements can-save and increments can-restore, with no trap.
- R4: A save with can-save equal to 0 raises a spill trap and moves the pointer up by 2 modulo NWIN. All counts stay unchanged.
- R5: A save with can-save nonzero and clean equal to can-restore raises the clean-window trap (code 5) and moves the pointer up by 1 modulo NWIN. All counts stay unchanged.
- R6: Spill and fill traps use the other kind when the other count is nonzero and the normal kind otherwise. The codes are spill-normal 1, spill-other 2, fill-normal 3 and fill-other 4. `trap_vec` carries `wstate_other` for the other kinds, `wstate_normal` for the normal kinds, and 0 for every other code.
- R7: A restore always moves the pointer down by 1 modulo NWIN, with 0 wrapping to NWIN-1. When can-restore is 0 it raises a fill trap and leaves the counts unchanged. Otherwise it increments can-save and decrements can-restore.
- R8: A return whose target address bits [1:0] are nonzero raises the misaligned trap (code 6) and changes no state. With those bits at zero it behaves exactly as a restore.
- R9: A flush raises a spill trap unless can-save equals NWIN-2. A flush never changes the pointer or the counts.
- R10: An idle request, or an unused request code (5 to 7), leaves all state unchanged and sets the trap code to none. `trap_valid` is high exactly when the code is not none.
- R11: In a save, the can-save test comes before the clean test. With can-save 0 the trap is a spill even when clean equals can-restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 3 | Request code (R3 encoding) |
| tgt_lo | input | 2 | Low two bits of the return target address |
| wr_en | input | 1 | Load all state values from the write inputs |
| wr_cwp | input | CW | Pointer value to load |
| wr_cansave | input | CW | Can-save count to load |
| wr_canrestore | input | CW | Can-restore count to load |
| wr_cleanwin | input | CW | Clean-window count to load |
| wr_otherwin | input | CW | Other-window count to load |
| wstate_normal | input | WSW | Vector field for normal spill/fill traps |
| wstate_other | input | WSW | Vector field for other spill/fill traps |
| cwp | output | CW | Current window pointer |
| cansave | output | CW | Can-save count |
| canrestore | output | CW | Can-restore count |
| cleanwin | output | CW | Clean-window count |
| otherwin | output | CW | Other-window count |
| trap_valid | output | 1 | A trap was raised by the previous request |
| trap_code | output | 3 | Trap code (R6/R5/R8 encoding) |
| trap_vec | output | WSW | Selected window-state field |

## Verification
The block samples a request or a write on a rising edge. The pointer, the counts, the trap code and the vector all show the outcome right after that same edge, one cycle after the request. The bench drives each request on a falling edge and advances its behavioural model at that moment. It compares every output on the following falling edge, one full cycle later. Because the outputs are compared every cycle, a state change that should not happen after an ignored request is also caught, on the next compare.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_SAVE    = 3'd1,
        OP_RESTORE = 3'd2,
        OP_RETURN  = 3'd3,
        OP_FLUSH   = 3'd4
    } win_op_e;

    typedef enum logic [2:0] {
        TC_NONE     = 3'd0,
        TC_SPILL_N  = 3'd1,
        TC_SPILL_O  = 3'd2,
        TC_FILL_N   = 3'd3,
        TC_FILL_O   = 3'd4,
        TC_CLEAN    = 3'd5,
        TC_MISALIGN = 3'd6
    } trap_code_e;

    // forward step with k <= n, p < n; one conditional subtract suffices
    function automatic int unsigned wrap_fwd(input int unsigned p,
                                             input int unsigned k,
                                             input int unsigned n);
        int unsigned s;
        s = p + k;
        if (s >= n) s = s - n;
        if (s >= n) s = s - n;
        return s;
    endfunction

    function automatic int unsigned wrap_back(input int unsigned p,
                                              input int unsigned n);
        return (p == 0) ? (n - 1) : (p - 1);
    endfunction

    function automatic logic uses_other(input trap_code_e c);
        return (c == TC_SPILL_O) || (c == TC_FILL_O);
    endfunction

    function automatic logic uses_normal(input trap_code_e c);
        return (c == TC_SPILL_N) || (c == TC_FILL_N);
    endfunction

endpackage

// File: rtl/rwin_decide.sv
module rwin_decide
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = 3
) (
    input  win_op_e          op,
    input  logic [1:0]       tgt_lo,
    input  logic [CW-1:0]    cwp,
    input  logic [CW-1:0]    cansave,
    input  logic [CW-1:0]    canrestore,
    input  logic [CW-1:0]    cleanwin,
    input  logic             other_nz,
    output logic [CW-1:0]    nx_cwp,
    output logic [CW-1:0]    nx_cansave,
    output logic [CW-1:0]    nx_canrestore,
    output trap_code_e       nx_trap
);

    localparam int unsigned FLUSH_FULL = NWIN - 2;

    function automatic logic [CW-1:0] ptr_up(input logic [CW-1:0] p, input int unsigned k);
        return CW'(wrap_fwd(32'(p), k, NWIN));
    endfunction

    function automatic logic [CW-1:0] ptr_down(input logic [CW-1:0] p);
        return CW'(wrap_back(32'(p), NWIN));
    endfunction

    trap_code_e spill_kind, fill_kind;
    assign spill_kind = other_nz ? TC_SPILL_O : TC_SPILL_N;
    assign fill_kind  = other_nz ? TC_FILL_O  : TC_FILL_N;

    always_comb begin
        nx_cwp        = cwp;
        nx_cansave    = cansave;
        nx_canrestore = canrestore;
        nx_trap       = TC_NONE;
        case (op)
            OP_SAVE: begin
                if (cansave == '0) begin
                    nx_trap = spill_kind;
                    nx_cwp  = ptr_up(cwp, 2);
                end else if (cleanwin == canrestore) begin
                    nx_trap = TC_CLEAN;
                    nx_cwp  = ptr_up(cwp, 1);
                end else begin
                    nx_cwp        = ptr_up(cwp, 1);
                    nx_cansave    = cansave - 1'b1;
                    nx_canrestore = canrestore + 1'b1;
                end
            end
            OP_RESTORE, OP_RETURN: begin
                if (op == OP_RETURN && tgt_lo != 2'b00) begin
                    nx_trap = TC_MISALIGN;
                end else begin
                    nx_cwp = ptr_down(cwp);
                    if (canrestore == '0) begin
                        nx_trap = fill_kind;
                    end else begin
                        nx_cansave    = cansave + 1'b1;
                        nx_canrestore = canrestore - 1'b1;
                    end
                end
            end
            OP_FLUSH: begin
                if (cansave != CW'(FLUSH_FULL)) nx_trap = spill_kind;
            end
            default: ;
        endcase
    end

    // R5 clean trap only ever comes from a save with room to save
    always_comb begin
        if (nx_trap == TC_CLEAN)
            clean_src_chk: assert (op == OP_SAVE && cansave != '0);
    end

endmodule

// File: rtl/rwin_state.sv
module rwin_state
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = 3,
    parameter int WSW  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_cwp,
    input  logic [CW-1:0]    wr_cansave,
    input  logic [CW-1:0]    wr_canrestore,
    input  logic [CW-1:0]    wr_cleanwin,
    input  logic [CW-1:0]    wr_otherwin,
    input  logic [CW-1:0]    nx_cwp,
    input  logic [CW-1:0]    nx_cansave,
    input  logic [CW-1:0]    nx_canrestore,
    input  trap_code_e       nx_trap,
    input  logic [WSW-1:0]   wstate_normal,
    input  logic [WSW-1:0]   wstate_other,
    output logic [CW-1:0]    cwp,
    output logic [CW-1:0]    cansave,
    output logic [CW-1:0]    canrestore,
    output logic [CW-1:0]    cleanwin,
    output logic [CW-1:0]    otherwin,
    output trap_code_e       trap_code,
    output logic [WSW-1:0]   trap_vec
);

    localparam logic [CW-1:0] RST_SAVE = CW'(NWIN - 2);

    logic [WSW-1:0] vec_sel;
    always_comb begin
        if (uses_other(nx_trap))       vec_sel = wstate_other;
        else if (uses_normal(nx_trap)) vec_sel = wstate_normal;
        else                           vec_sel = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp        <= '0;
            cansave    <= RST_SAVE;
            canrestore <= '0;
            cleanwin   <= RST_SAVE;
            otherwin   <= '0;
            trap_code  <= TC_NONE;
            trap_vec   <= '0;
        end else if (wr_en) begin
            cwp        <= wr_cwp;
            cansave    <= wr_cansave;
            canrestore <= wr_canrestore;
            cleanwin   <= wr_cleanwin;
            otherwin   <= wr_otherwin;
            trap_code  <= TC_NONE;
            trap_vec   <= '0;
        end else begin
            cwp        <= nx_cwp;
            cansave    <= nx_cansave;
            canrestore <= nx_canrestore;
            trap_code  <= nx_trap;
            trap_vec   <= vec_sel;
        end
    end

    // R2
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (trap_code == TC_NONE) && (cansave == $past(wr_cansave))
                  && (cwp == $past(wr_cwp)));

endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int WSW  = 3,
    localparam int CW  = $clog2(NWIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       req_op,
    input  logic [1:0]       tgt_lo,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_cwp,
    input  logic [CW-1:0]    wr_cansave,
    input  logic [CW-1:0]    wr_canrestore,
    input  logic [CW-1:0]    wr_cleanwin,
    input  logic [CW-1:0]    wr_otherwin,
    input  logic [WSW-1:0]   wstate_normal,
    input  logic [WSW-1:0]   wstate_other,
    output logic [CW-1:0]    cwp,
    output logic [CW-1:0]    cansave,
    output logic [CW-1:0]    canrestore,
    output logic [CW-1:0]    cleanwin,
    output logic [CW-1:0]    otherwin,
    output logic             trap_valid,
    output logic [2:0]       trap_code,
    output logic [WSW-1:0]   trap_vec
);

    win_op_e       op;
    trap_code_e    nx_trap, code_q;
    logic [CW-1:0] nx_cwp, nx_cansave, nx_canrestore;

    assign op = win_op_e'(req_op);

    rwin_decide #(.NWIN(NWIN), .CW(CW)) u_decide (
        .op            (op),
        .tgt_lo        (tgt_lo),
        .cwp           (cwp),
        .cansave       (cansave),
        .canrestore    (canrestore),
        .cleanwin      (cleanwin),
        .other_nz      (otherwin != '0),
        .nx_cwp        (nx_cwp),
        .nx_cansave    (nx_cansave),
        .nx_canrestore (nx_canrestore),
        .nx_trap       (nx_trap)
    );

    rwin_state #(.NWIN(NWIN), .CW(CW), .WSW(WSW)) u_state (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_cwp        (wr_cwp),
        .wr_cansave    (wr_cansave),
        .wr_canrestore (wr_canrestore),
        .wr_cleanwin   (wr_cleanwin),
        .wr_otherwin   (wr_otherwin),
        .nx_cwp        (nx_cwp),
        .nx_cansave    (nx_cansave),
        .nx_canrestore (nx_canrestore),
        .nx_trap       (nx_trap),
        .wstate_normal (wstate_normal),
        .wstate_other  (wstate_other),
        .cwp           (cwp),
        .cansave       (cansave),
        .canrestore    (canrestore),
        .cleanwin      (cleanwin),
        .otherwin      (otherwin),
        .trap_code     (code_q),
        .trap_vec      (trap_vec)
    );

    assign trap_code  = code_q;
    assign trap_valid = (code_q != TC_NONE);

    // R3 R7: moving a window between the two pools keeps their sum
    sum_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && cansave != CW'(2**CW - 1) && canrestore != CW'(2**CW - 1))
        |=> (CW'(cansave + canrestore) == $past(CW'(cansave + canrestore))));

    // R7
    restore_back_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && op == OP_RESTORE)
        |=> (cwp == (($past(cwp) == '0) ? CW'(NWIN - 1) : CW'($past(cwp) - 1'b1))));

    // R8
    misalign_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && op == OP_RETURN && tgt_lo != 2'b00)
        |=> ($stable(cwp) && $stable(cansave) && code_q == TC_MISALIGN));

    // R9
    flush_still_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && op == OP_FLUSH) |=> ($stable(cwp) && $stable(canrestore)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && op == OP_IDLE) |=> (!trap_valid && $stable(cwp) && $stable(cansave)));

endmodule

// File: tb/rwin_ctrl_bench.sv
`timescale 1ns/1ps
module rwin_ctrl_bench;
    localparam int NWIN = 8;
    localparam int WSW  = 3;
    localparam int CW   = $clog2(NWIN);
    localparam int MSK  = (1 << CW) - 1;
    localparam logic [WSW-1:0] WS_N = 3'd5;
    localparam logic [WSW-1:0] WS_O = 3'd2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] req_op = '0;
    logic [1:0] tgt_lo = '0;
    logic wr_en = 1'b0;
    logic [CW-1:0] wr_cwp = '0, wr_cansave = '0, wr_canrestore = '0, wr_cleanwin = '0, wr_otherwin = '0;
    logic [WSW-1:0] wstate_normal = WS_N, wstate_other = WS_O;
    logic [CW-1:0] cwp, cansave, canrestore, cleanwin, otherwin;
    logic trap_valid;
    logic [2:0] trap_code;
    logic [WSW-1:0] trap_vec;

    always #2.5 clk = ~clk;

    rwin_ctrl #(.NWIN(NWIN), .WSW(WSW)) u_rwin_ctrl (
        .clk(clk), .rst(rst), .req_op(req_op), .tgt_lo(tgt_lo), .wr_en(wr_en),
        .wr_cwp(wr_cwp), .wr_cansave(wr_cansave), .wr_canrestore(wr_canrestore),
        .wr_cleanwin(wr_cleanwin), .wr_otherwin(wr_otherwin),
        .wstate_normal(wstate_normal), .wstate_other(wstate_other),
        .cwp(cwp), .cansave(cansave), .canrestore(canrestore), .cleanwin(cleanwin),
        .otherwin(otherwin), .trap_valid(trap_valid), .trap_code(trap_code), .trap_vec(trap_vec)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int m_cwp, m_cs, m_cr, m_cl, m_ow, m_tc, m_vec;

    task automatic compare(string tag);
        checks++;
        if (cwp !== CW'(m_cwp) || cansave !== CW'(m_cs) || canrestore !== CW'(m_cr) ||
            cleanwin !== CW'(m_cl) || otherwin !== CW'(m_ow) || trap_code !== 3'(m_tc) ||
            trap_valid !== (m_tc != 0) || trap_vec !== WSW'(m_vec)) begin
            fails++;
            $display("FAIL %s: got cwp=%0d cs=%0d cr=%0d cl=%0d ow=%0d tv=%0b tc=%0d vec=%0d exp cwp=%0d cs=%0d cr=%0d cl=%0d ow=%0d tv=%0b tc=%0d vec=%0d",
                     tag, cwp, cansave, canrestore, cleanwin, otherwin, trap_valid, trap_code, trap_vec,
                     m_cwp, m_cs, m_cr, m_cl, m_ow, (m_tc != 0), m_tc, m_vec);
        end
    endtask

    // behavioural model of one request cycle
    task automatic model_step(int op, int tgt, bit wr, int wc, int wcs, int wcr, int wcl, int wow);
        int kind_other;
        kind_other = (m_ow != 0);
        m_tc = 0;
        if (wr) begin
            m_cwp = wc; m_cs = wcs; m_cr = wcr; m_cl = wcl; m_ow = wow;
        end else if (op == 1) begin
            if (m_cs == 0) begin
                m_tc = kind_other ? 2 : 1;
                m_cwp = (m_cwp + 2) % NWIN;
            end else if (m_cl == m_cr) begin
                m_tc = 5;
                m_cwp = (m_cwp + 1) % NWIN;
            end else begin
                m_cwp = (m_cwp + 1) % NWIN;
                m_cs = m_cs - 1;
                m_cr = (m_cr + 1) & MSK;
            end
        end else if (op == 2 || op == 3) begin
            if (op == 3 && tgt != 0) m_tc = 6;
            else begin
                m_cwp = (m_cwp + NWIN - 1) % NWIN;
                if (m_cr == 0) m_tc = kind_other ? 4 : 3;
                else begin
                    m_cs = (m_cs + 1) & MSK;
                    m_cr = m_cr - 1;
                end
            end
        end else if (op == 4) begin
            if (m_cs != NWIN - 2) m_tc = kind_other ? 2 : 1;
        end
        m_vec = (m_tc == 2 || m_tc == 4) ? int'(WS_O) : (m_tc == 1 || m_tc == 3) ? int'(WS_N) : 0;
    endtask

    task automatic cycle(int op, int tgt, bit wr, int wc, int wcs, int wcr, int wcl, int wow, string tag);
        req_op = 3'(op); tgt_lo = 2'(tgt); wr_en = wr;
        wr_cwp = CW'(wc); wr_cansave = CW'(wcs); wr_canrestore = CW'(wcr);
        wr_cleanwin = CW'(wcl); wr_otherwin = CW'(wow);
        model_step(op, tgt, wr, wc, wcs, wcr, wcl, wow);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic req(int op, int tgt, string tag);
        cycle(op, tgt, 1'b0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic load(int wc, int wcs, int wcr, int wcl, int wow, string tag);
        cycle(1, 0, 1'b1, wc, wcs, wcr, wcl, wow, tag); // save request alongside is ignored
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got running exp finished");
            summary();
            $finish;
        end
    end

    initial begin
        m_cwp = 0; m_cs = NWIN - 2; m_cr = 0; m_cl = NWIN - 2; m_ow = 0; m_tc = 0; m_vec = 0;
        repeat (2) @(negedge clk);
        compare("R1");
        rst = 1'b0;
        req(0, 0, "R10");
        req(1, 0, "R3");
        req(1, 0, "R3");
        req(1, 0, "R3");
        req(4, 0, "R9");          // can-save 3 -> spill normal
        req(2, 0, "R7");
        req(3, 2, "R8");          // misaligned
        req(3, 1, "R8");
        req(3, 0, "R8");          // aligned return acts as restore
        req(2, 0, "R7");
        req(2, 0, "R7");          // can-restore 0 -> fill, pointer wraps to 7
        load(0, NWIN - 2, 0, NWIN - 2, 0, "R2");
        req(4, 0, "R9");          // full -> no trap
        req(5, 0, "R10");         // unused code
        load(7, 0, 6, 6, 2, "R2");
        req(1, 0, "R11");         // spill other, wrap 7+2 -> 1
        load(7, 0, 6, 6, 0, "R2");
        req(1, 0, "R4");          // spill normal
        load(7, 2, 3, 3, 0, "R2");
        req(1, 0, "R5");          // clean trap, wrap to 0
        load(0, 2, 0, 6, 1, "R2");
        req(2, 0, "R6");          // fill other
        req(4, 0, "R6");          // spill other on flush
        load(7, 3, 1, 6, 0, "R2");
        req(1, 0, "R3");          // wrap 7 -> 0
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 5));
            if ($urandom_range(0, 9) == 0)
                cycle(op, 0, 1'b1, int'($urandom_range(0, NWIN - 1)), int'($urandom_range(0, MSK)),
                      int'($urandom_range(0, MSK)), int'($urandom_range(0, MSK)),
                      int'($urandom_range(0, 1)), "R2");
            else
                req(op, int'($urandom_range(0, 3)),
                    op == 1 ? "R3" : op == 2 ? "R7" : op == 3 ? "R8" : op == 4 ? "R9" : "R10");
        end
        done = 1;
        summary();
        $finish;
    end
endmodule